// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block keeps the bookkeeping for up to 256 interrupt vectors on behalf of one processor. It holds three bit arrays, one bit per vector:

- **pending**: a request has arrived.
- **active**: the processor is servicing the vector.
- **level**: the request was level-triggered.

From a task priority value and the most urgent active vector it derives a processor priority. It then presents the most urgent pending vector whose priority class beats that priority.

A source of interrupts offers vectors on the accept port. The processor side works through three signals:

- It reads the query outputs to find the vector it would take next.
- It raises `ack` to take that vector into service.
- It raises `eoi` to retire the most urgent active vector.

When a level-triggered vector is retired, a one-cycle notification carrying its number goes out, so an upstream source can re-evaluate its line. Vectors 0 to 15 are reserved and never become pending.

Top module: `prio_vector_ctrl`

## Requirements
- R1: After reset all three arrays are empty, the task priority and the processor priority are 0, nothing is deliverable and the notification is low.
- R2: An accepted vector becomes pending in the next cycle. `acc_new` is high in the accept cycle exactly when the vector was not already pending. Its level bit becomes the value of `acc_level`, where 1 means level and 0 means edge.
- R3: A level-triggered request for a vector that is already pending is dropped and changes nothing. An edge-triggered repeat clears the vector's level bit.
- R4: Requests are ignored unless `hw_en` and `sw_en` are both 1.
- R5: Requests for vectors below 16 are ignored, so the query and the notification never report such a vector.
- R6: `dlv_valid` is high when the highest pending vector has (vector AND 0xF0) strictly greater than the processor priority. In that case `dlv_vec` is that vector.
- R7: The processor priority is derived from the task priority T and the highest active vector A, with A taken as 0 when nothing is active. If T[7:4] >= A[7:4], the priority is T. Otherwise it is A AND 0xF0. The value is registered and follows a change of T or of the active array one cycle later.
- R8: `ack`, while a vector is deliverable, marks that vector active and clears its pending bit. When nothing is deliverable, `ack` does nothing.
- R9: `eoi` clears the highest active bit. When no bit is active, `eoi` does nothing.
- R10: If the vector retired by `eoi` has its level bit set, that bit is cleared and `eoi_note` pulses for one cycle, one cycle after `eoi`, with the vector on `eoi_note_vec`. In every other cycle `eoi_note_vec` is 0.
- R11: A task priority write keeps bits 7:0 of `tpr_wdata` and drops the rest.
- R12: When accept and `ack` meet in one cycle, both work from the state at the start of the cycle, and the accept is applied on top of the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_en | input | 1 | Hardware enable for accepts |
| sw_en | input | 1 | Software enable for accepts |
| acc_valid | input | 1 | Accept request strobe |
| acc_vec | input | 8 | Requested vector |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge |
| acc_new | output | 1 | Accept found the vector not pending |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_wdata | input | 32 | Task priority write data |
| tpr_o | output | 8 | Current task priority |
| ppr_o | output | 8 | Current processor priority |
| dlv_valid | output | 1 | A vector is deliverable |
| dlv_vec | output | 8 | Deliverable vector |
| ack | input | 1 | Take the deliverable vector into service |
| eoi | input | 1 | Retire the highest active vector |
| eoi_note | output | 1 | Level-triggered vector retired |
| eoi_note_vec | output | 8 | Vector of the retirement notice |

## Verification
The checker watches several cheap invariants on every cycle:

- an acceptance is reported only while both enables are set and only for an unreserved vector;
- neither the query nor the notification ever names a reserved vector;
- a notification always follows an `eoi` in the previous cycle;
- the task priority moves only after a write.

The bench's reference model covers the things no single-cycle property captures. These are the strict class comparison at its boundary, the one-cycle lag of the processor priority, nested service retiring in priority order, drops of duplicate level requests, and the interplay of a same-cycle accept and acknowledge. The model shows each of these through the query and notification outputs.

// File: rtl/pivc_pkg.sv
// Shared constants and types for the prioritized interrupt vector controller.
package pivc_pkg;
    // Lowest bit of a vector's priority class field.
    localparam int unsigned CLS_LSB = 4;

    // Trigger kind recorded per vector.
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;
endpackage

// File: rtl/pivc_hs_enc.sv
// Highest-set-bit encoder.
// Reports whether any bit of bits_i is set and the index of the most
// significant set bit. Purely combinational; assumes WIDTH is a power of two.
module pivc_hs_enc #(
    parameter  int unsigned WIDTH = 256,
    localparam int unsigned IW    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits_i,
    output logic             found_o,
    output logic [IW-1:0]    idx_o
);
    // Scan upward so the last hit, the highest one, wins.
    always_comb begin
        found_o = |bits_i;
        idx_o   = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (bits_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/pivc_ppr.sv
// Processor priority register.
// Compares the task priority class with the class of the highest active
// vector and registers the result, so it lags its inputs by one cycle.
// Assumes isr_top_i is meaningful only when isr_found_i is high.
module pivc_ppr
    import pivc_pkg::*;
#(
    parameter int unsigned VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] tpr_i,
    input  logic          isr_found_i,
    input  logic [VW-1:0] isr_top_i,
    output logic [VW-1:0] ppr_o
);
    logic [VW-1:0] isr_eff;
    logic [VW-1:0] ppr_nxt;

    // Pick the task priority or the active vector's class, whichever is higher.
    always_comb begin
        isr_eff = isr_found_i ? isr_top_i : '0;
        if (tpr_i[VW-1:CLS_LSB] >= isr_eff[VW-1:CLS_LSB])
            ppr_nxt = tpr_i;
        else
            ppr_nxt = {isr_eff[VW-1:CLS_LSB], {CLS_LSB{1'b0}}};
    end

    // Register the priority.
    always_ff @(posedge clk) begin
        if (!rst_n) ppr_o <= '0;
        else        ppr_o <= ppr_nxt;
    end
endmodule

// File: rtl/pivc_arrays.sv
// Pending, active and level bit arrays with their update rules.
// All decisions use the state at the start of the cycle. Acknowledge and
// retire are applied first, the accept on top. Assumes ack_do_i and eoi_do_i
// are already qualified (a deliverable or an active vector exists).
module pivc_arrays
    import pivc_pkg::*;
#(
    parameter  int unsigned NVEC = 256,
    parameter  int unsigned RSVD = 16,
    localparam int unsigned VW   = $clog2(NVEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_en_i,
    input  logic [VW-1:0]   acc_vec_i,
    input  trig_e           acc_trig_i,
    input  logic            ack_do_i,
    input  logic [VW-1:0]   ack_vec_i,
    input  logic            eoi_do_i,
    input  logic [VW-1:0]   eoi_vec_i,
    output logic [NVEC-1:0] irr_o,
    output logic [NVEC-1:0] isr_o,
    output logic            acc_new_o,
    output logic            note_o,
    output logic [VW-1:0]   note_vec_o
);
    logic [NVEC-1:0] tmr_q;
    logic [NVEC-1:0] acc_oh, ack_oh, eoi_oh;
    logic [NVEC-1:0] irr_d, isr_d, tmr_d;
    logic            acc_take, acc_orig, acc_write, note_d;

    // Qualify the accept: unreserved vector, level repeats dropped.
    always_comb begin
        acc_take  = acc_en_i && (acc_vec_i >= VW'(RSVD));
        acc_orig  = irr_o[acc_vec_i];
        acc_write = acc_take && !(acc_orig && (acc_trig_i == TRIG_LEVEL));
        acc_new_o = acc_take && !acc_orig;
    end

    // One-hot masks for the three operations.
    always_comb begin
        acc_oh = acc_write ? (NVEC'(1) << acc_vec_i) : '0;
        ack_oh = ack_do_i  ? (NVEC'(1) << ack_vec_i) : '0;
        eoi_oh = eoi_do_i  ? (NVEC'(1) << eoi_vec_i) : '0;
    end

    // Next state: acknowledge or retire first, accept last.
    always_comb begin
        irr_d  = (irr_o & ~ack_oh) | acc_oh;
        isr_d  = (isr_o & ~eoi_oh) | ack_oh;
        tmr_d  = (tmr_q & ~eoi_oh & ~acc_oh)
               | ((acc_trig_i == TRIG_LEVEL) ? acc_oh : '0);
        note_d = eoi_do_i && tmr_q[eoi_vec_i];
    end

    // Array registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_o <= '0;
            isr_o <= '0;
            tmr_q <= '0;
        end else begin
            irr_o <= irr_d;
            isr_o <= isr_d;
            tmr_q <= tmr_d;
        end
    end

    // Retirement notice for level-triggered vectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            note_o     <= 1'b0;
            note_vec_o <= '0;
        end else begin
            note_o     <= note_d;
            note_vec_o <= note_d ? eoi_vec_i : '0;
        end
    end
endmodule

// File: rtl/prio_vector_ctrl.sv
// Prioritized interrupt vector controller, top level.
// Holds the task priority, finds the highest pending and the highest active
// vector, and offers the deliverable one. Inputs are synchronous to clk;
// ack and eoi are single-cycle strobes acted on only when meaningful.
module prio_vector_ctrl
    import pivc_pkg::*;
#(
    parameter  int unsigned NVEC    = 256,
    parameter  int unsigned RSVD    = 16,
    parameter  int unsigned WDATA_W = 32,
    localparam int unsigned VW      = $clog2(NVEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_en,
    input  logic               sw_en,
    input  logic               acc_valid,
    input  logic [VW-1:0]      acc_vec,
    input  logic               acc_level,
    output logic               acc_new,
    input  logic               tpr_wr,
    input  logic [WDATA_W-1:0] tpr_wdata,
    output logic [VW-1:0]      tpr_o,
    output logic [VW-1:0]      ppr_o,
    output logic               dlv_valid,
    output logic [VW-1:0]      dlv_vec,
    input  logic               ack,
    input  logic               eoi,
    output logic               eoi_note,
    output logic [VW-1:0]      eoi_note_vec
);
    logic [NVEC-1:0] irr, isr;
    logic            irr_found, isr_found;
    logic [VW-1:0]   irr_top, isr_top;
    logic            unused_wdata;

    assign unused_wdata = ^tpr_wdata[WDATA_W-1:VW];

    // Task priority register, low bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)      tpr_o <= '0;
        else if (tpr_wr) tpr_o <= tpr_wdata[VW-1:0];
    end

    // Highest pending vector.
    pivc_hs_enc #(.WIDTH(NVEC)) u_irr_enc (
        .bits_i (irr),
        .found_o(irr_found),
        .idx_o  (irr_top)
    );

    // Highest active vector.
    pivc_hs_enc #(.WIDTH(NVEC)) u_isr_enc (
        .bits_i (isr),
        .found_o(isr_found),
        .idx_o  (isr_top)
    );

    pivc_ppr #(.VW(VW)) u_ppr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tpr_i      (tpr_o),
        .isr_found_i(isr_found),
        .isr_top_i  (isr_top),
        .ppr_o      (ppr_o)
    );

    // Deliverable when the pending class strictly beats the priority.
    always_comb begin
        dlv_valid = irr_found &&
                    ({irr_top[VW-1:CLS_LSB], {CLS_LSB{1'b0}}} > ppr_o);
        dlv_vec   = dlv_valid ? irr_top : '0;
    end

    pivc_arrays #(.NVEC(NVEC), .RSVD(RSVD)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en_i  (acc_valid && hw_en && sw_en),
        .acc_vec_i (acc_vec),
        .acc_trig_i(acc_level ? TRIG_LEVEL : TRIG_EDGE),
        .ack_do_i  (ack && dlv_valid),
        .ack_vec_i (irr_top),
        .eoi_do_i  (eoi && isr_found),
        .eoi_vec_i (isr_top),
        .irr_o     (irr),
        .isr_o     (isr),
        .acc_new_o (acc_new),
        .note_o    (eoi_note),
        .note_vec_o(eoi_note_vec)
    );
endmodule

// File: rtl/pivc_sva.sv
// Checker for the prioritized interrupt vector controller, bound to the top.
// Observes ports only; all properties are disabled while reset is low.
module pivc_sva #(
    parameter int unsigned VW   = 8,
    parameter int unsigned RSVD = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hw_en,
    input logic          sw_en,
    input logic          acc_valid,
    input logic [VW-1:0] acc_vec,
    input logic          acc_new,
    input logic          tpr_wr,
    input logic [VW-1:0] tpr_o,
    input logic          dlv_valid,
    input logic [VW-1:0] dlv_vec,
    input logic          eoi,
    input logic          eoi_note,
    input logic [VW-1:0] eoi_note_vec
);
    // R4: a new acceptance needs a request and both enables.
    a_r4_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        acc_new |-> (acc_valid && hw_en && sw_en));

    // R5: reserved vectors are never accepted.
    a_r5_rsvd_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc_new |-> (acc_vec >= VW'(RSVD)));

    // R5: the query never offers a reserved vector.
    a_r5_rsvd_query: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_vec >= VW'(RSVD)));

    // R10: a notice follows a retire request and names an unreserved vector.
    a_r10_note_after_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_note |-> ($past(eoi) && (eoi_note_vec >= VW'(RSVD))));

    // R11: the task priority changes only after a write.
    a_r11_tpr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tpr_wr) |-> $stable(tpr_o));
endmodule

bind prio_vector_ctrl pivc_sva #(.VW(VW), .RSVD(RSVD)) u_pivc_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_en       (hw_en),
    .sw_en       (sw_en),
    .acc_valid   (acc_valid),
    .acc_vec     (acc_vec),
    .acc_new     (acc_new),
    .tpr_wr      (tpr_wr),
    .tpr_o       (tpr_o),
    .dlv_valid   (dlv_valid),
    .dlv_vec     (dlv_vec),
    .eoi         (eoi),
    .eoi_note    (eoi_note),
    .eoi_note_vec(eoi_note_vec)
);

// File: tb/prio_vector_ctrl_test.sv
// Bench: behavioural reference model compared with the design every cycle.
module prio_vector_ctrl_test;
    localparam int NV    = 256;
    localparam int LIMIT = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_en = 1'b1, sw_en = 1'b1;
    logic        acc_valid = 1'b0, acc_level = 1'b0;
    logic [7:0]  acc_vec = '0;
    logic        acc_new;
    logic        tpr_wr = 1'b0;
    logic [31:0] tpr_wdata = '0;
    logic [7:0]  tpr_o, ppr_o, dlv_vec, eoi_note_vec;
    logic        dlv_valid, ack = 1'b0, eoi = 1'b0, eoi_note;

    int  total = 0, bad = 0;
    bit  done = 0;

    // reference state
    bit [NV-1:0] m_irr, m_isr, m_tmr;
    int m_tpr, m_ppr, m_note_vec;
    bit m_note;

    always #10 clk = ~clk;

    prio_vector_ctrl uut (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
        .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level),
        .acc_new(acc_new), .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
        .tpr_o(tpr_o), .ppr_o(ppr_o), .dlv_valid(dlv_valid),
        .dlv_vec(dlv_vec), .ack(ack), .eoi(eoi), .eoi_note(eoi_note),
        .eoi_note_vec(eoi_note_vec)
    );

    function automatic int top_of(bit [NV-1:0] a);
        int r = -1;
        for (int i = 0; i < NV; i++) if (a[i]) r = i;
        return r;
    endfunction

    function automatic int exp_dlv();
        int h = top_of(m_irr);
        if (h >= 0 && (h & 8'hF0) > m_ppr) return h;
        return -1;
    endfunction

    task automatic chk(int act, int exp, string req, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        int d = exp_dlv();
        chk(int'(dlv_valid), int'(d >= 0), req, "dlv_valid");
        if (d >= 0) chk(int'(dlv_vec), d, req, "dlv_vec");
        chk(int'(ppr_o), m_ppr, req, "ppr");
        chk(int'(tpr_o), m_tpr, req, "tpr");
        chk(int'(eoi_note), int'(m_note), req, "eoi_note");
        chk(int'(eoi_note_vec), m_note_vec, req, "eoi_note_vec");
    endtask

    // Advance the model over one clock edge using the held inputs.
    task automatic model_step();
        int  hi_isr = top_of(m_isr);
        int  d      = exp_dlv();
        int  ih     = (hi_isr >= 0) ? hi_isr : 0;
        int  nppr;
        bit  nnote  = 0;
        int  nvec   = 0;
        bit  orig;
        nppr = ((m_tpr & 8'hF0) >= (ih & 8'hF0)) ? m_tpr : (ih & 8'hF0);
        if (ack && d >= 0) begin
            m_isr[d] = 1'b1;
            m_irr[d] = 1'b0;
        end
        if (eoi && hi_isr >= 0) begin
            m_isr[hi_isr] = 1'b0;
            if (m_tmr[hi_isr]) begin
                nnote = 1;
                nvec  = hi_isr;
                m_tmr[hi_isr] = 1'b0;
            end
        end
        if (acc_valid && hw_en && sw_en && acc_vec >= 16) begin
            orig = m_irr[acc_vec] && !(ack && d == int'(acc_vec)) ? 1'b1 :
                   (ack && d == int'(acc_vec));
            if (!(orig && acc_level)) begin
                m_irr[acc_vec] = 1'b1;
                m_tmr[acc_vec] = acc_level;
            end
        end
        if (tpr_wr) m_tpr = tpr_wdata & 32'hFF;
        m_ppr = nppr;
        m_note = nnote;
        m_note_vec = nvec;
    endtask

    // One cycle: check, drive, check the accept flag, clock, update model.
    task automatic cyc(string req, bit av = 0, int v = 0, bit lvl = 0,
                       bit a = 0, bit e = 0, bit tw = 0, int twd = 0);
        bit exp_new;
        @(negedge clk);
        compare_all(req);
        acc_valid = av; acc_vec = 8'(v); acc_level = lvl;
        ack = a; eoi = e; tpr_wr = tw; tpr_wdata = twd;
        #1;
        exp_new = av && hw_en && sw_en && v >= 16 && !m_irr[v];
        chk(int'(acc_new), int'(exp_new), req, "acc_new");
        @(posedge clk);
        #1;
        model_step();
    endtask

    task automatic idle(string req, int n);
        for (int i = 0; i < n; i++) cyc(req);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_irr = '0; m_isr = '0; m_tmr = '0;
        m_tpr = 0; m_ppr = 0; m_note = 0; m_note_vec = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle("R1", 2);
        // R2: first accept flags new, repeat does not
        cyc("R2", 1, 'h40, 0);
        cyc("R2", 1, 'h40, 0);
        idle("R2", 1);
        // R6/R11: class boundary against the task priority
        cyc("R6", 1, 'h80, 1);
        cyc("R11", 0, 0, 0, 0, 0, 1, 'h1234_5690);
        idle("R7", 2);
        cyc("R6", 0, 0, 0, 0, 0, 1, 'h7F);
        idle("R6", 2);
        cyc("R6", 0, 0, 0, 0, 0, 1, 'h80);
        idle("R6", 2);
        cyc("R7", 0, 0, 0, 0, 0, 1, 'h0);
        idle("R7", 2);
        // R8: acknowledge, priority follows one cycle later
        cyc("R8", 0, 0, 0, 1);
        idle("R7", 2);
        // R9/R10: retire a level vector, notice pulses
        cyc("R10", 0, 0, 0, 0, 1);
        idle("R10", 2);
        // R10: edge vector retires silently
        cyc("R8", 0, 0, 0, 1);
        idle("R8", 2);
        cyc("R10", 0, 0, 0, 0, 1);
        idle("R10", 2);
        // R3: level repeat on an edge-pending vector is dropped
        cyc("R3", 1, 'h60, 0);
        cyc("R3", 1, 'h60, 1);
        cyc("R3", 0, 0, 0, 1);
        idle("R3", 2);
        cyc("R3", 0, 0, 0, 0, 1);
        idle("R3", 2);
        // R3: edge repeat clears the level bit
        cyc("R3", 1, 'h70, 1);
        cyc("R3", 1, 'h70, 0);
        cyc("R3", 0, 0, 0, 1);
        idle("R3", 2);
        cyc("R3", 0, 0, 0, 0, 1);
        idle("R3", 2);
        // R4: enables gate accepts
        hw_en = 1'b0;
        cyc("R4", 1, 'h90, 1);
        idle("R4", 1);
        hw_en = 1'b1; sw_en = 1'b0;
        cyc("R4", 1, 'h91, 1);
        idle("R4", 1);
        sw_en = 1'b1;
        // R5: reserved vectors ignored, 16 accepted
        cyc("R5", 1, 'h0F, 1);
        idle("R5", 1);
        cyc("R5", 1, 'h10, 1);
        idle("R5", 1);
        cyc("R5", 0, 0, 0, 1);
        idle("R5", 2);
        cyc("R5", 0, 0, 0, 0, 1);
        idle("R5", 2);
        // R9: retire with nothing active
        cyc("R9", 0, 0, 0, 0, 1);
        idle("R9", 2);
        // R9: nested service retires highest first
        cyc("R9", 1, 'h30, 1);
        cyc("R9", 0, 0, 0, 1);
        idle("R9", 2);
        cyc("R9", 1, 'hFF, 1);
        cyc("R9", 0, 0, 0, 1);
        idle("R9", 2);
        cyc("R9", 0, 0, 0, 0, 1);
        idle("R9", 2);
        cyc("R9", 0, 0, 0, 0, 1);
        idle("R9", 2);
        // R12: accept and acknowledge of the same vector in one cycle
        cyc("R12", 1, 'h50, 0);
        cyc("R12", 1, 'h50, 0, 1);
        idle("R12", 2);
        cyc("R12", 0, 0, 0, 0, 1);
        idle("R12", 2);
        cyc("R12", 1, 'h50, 1, 1);
        idle("R12", 2);
        cyc("R12", 0, 0, 0, 0, 1);
        idle("R12", 3);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule